// File: doc/BRIEF.md
# Multi-Frame Back-Projection Pixel Updater

This block performs the refinement step of an iterative back-projection super-resolution loop. For every high-resolution pixel presented, it receives the pixel's current estimate together with, for each of `FRAMES` low-resolution frames, the observed and simulated values of the `TAPS` low-resolution pixels that the high-resolution pixel influences, plus one weight per tap. Each frame has its own branch. A branch forms the sum of (observed − simulated) × weight over its taps. A registered adder tree joins all branch sums with the current estimate. The tree is ⌈log2(FRAMES+1)⌉ levels deep.

The refined value is rounded to 8 bits, not truncated, and clamped to the pixel range. Rounded pixels come out one per cycle. They are also gathered four at a time into a 32-bit word for a packed memory write. The pipeline accepts a new pixel on every cycle and tolerates idle cycles between pixels.

Top module: `bp_pixel_update`

## Requirements
- R1: The refined pixel equals the current pixel plus the sum, over all frames and taps, of (observed − simulated) × weight. The residual is a signed 9-bit value. The weight is unsigned 8-bit with 6 fractional bits, so weight 64 means 1.0. The sum is kept at full precision until the final rounding.
- R2: `pixValid` rises exactly ⌈log2(FRAMES+1)⌉ + 2 cycles after the cycle in which `inValid` was sampled high. That is 6 cycles for FRAMES from 8 to 15.
- R3: A new pixel is accepted on every cycle. Back-to-back inputs give back-to-back results in the same order.
- R4: Rounding is half-up toward positive infinity. An exact fraction of one half rounds up for both positive and negative residual sums.
- R5: Results below 0 give 0, and results above 255 give 255.
- R6: Every fourth valid pixel raises `wordValid` in the same cycle as its `pixValid`. The word holds the first pixel of the group in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R7: A frame whose tap weights are all zero adds exactly nothing, whatever its observed and simulated pixels are.
- R8: After reset, `pixValid`, `wordValid`, `pixOut` and `wordOut` are zero, and the next valid pixel starts a new word in bits 7:0.
- R9: Cycles with `inValid` low produce no output pixel and do not advance the four-pixel grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pixel set valid this cycle |
| curPix | input | 8 | Current high-resolution estimate |
| obsPix | input | FRAMES*TAPS*8 (256) | Observed low-resolution pixels, frame-major then tap |
| simPix | input | FRAMES*TAPS*8 (256) | Simulated low-resolution pixels, same order |
| tapWgt | input | FRAMES*TAPS*8 (256) | Unsigned per-tap weights, 6 fractional bits |
| pixValid | output | 1 | Refined pixel valid |
| pixOut | output | 8 | Rounded, clamped refined pixel |
| wordValid | output | 1 | Packed word complete |
| wordOut | output | 32 | Four packed refined pixels |

## Verification
The grouping counter is the state that is hardest to reach from the ports. It only shows up every fourth result, and it must survive idle gaps and restart after a reset that arrives in the middle of a group. The stimulus therefore mixes random idle cycles into long random runs. It also asserts reset after two pixels of a group, then checks that the next four pixels land in a fresh word starting at the low byte. Exact rounding halves are produced with directed sets that use a weight of one half and residuals of ±1 and −3.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic       roundLoad;  // tree root holds a valid pixel sum this cycle
    logic       wordLoad;   // this pixel completes a packed word
    logic [1:0] slot;       // byte lane of this pixel inside the word
  } bpStrobe_t;
endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output bpStrobe_t stb,
  output logic      pixValid,
  output logic      wordValid
);
  localparam int LAT = DEPTH + 2;

  logic [DEPTH:0] vPipe;
  logic [1:0]     slot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[DEPTH-1:0], inValid};
  end

  always_comb begin
    stb.roundLoad = vPipe[DEPTH];
    stb.slot      = slot;
    stb.wordLoad  = vPipe[DEPTH] && (slot == 2'd3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot      <= '0;
      pixValid  <= 1'b0;
      wordValid <= 1'b0;
    end else begin
      pixValid  <= stb.roundLoad;
      wordValid <= stb.wordLoad;
      if (stb.roundLoad) slot <= slot + 2'd1;
    end
  end

  // count of pixels in flight, checked against the pipeline length
  logic [7:0] inFlight;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= inFlight + 8'(inValid) - 8'(pixValid);
  end

  assert_inflight_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 8'(LAT));
  assert_word_with_pixel_R6: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> pixValid);
  assert_slot_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wordLoad |=> (slot == 2'd0));
endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int FRAMES = 8,
  parameter int TAPS   = 4,
  parameter int PIX_W  = 8,
  parameter int WGT_W  = 8,
  parameter int FRAC_W = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bpStrobe_t                     stb,
  input  logic [PIX_W-1:0]              curPix,
  input  logic [FRAMES*TAPS*PIX_W-1:0]  obsPix,
  input  logic [FRAMES*TAPS*PIX_W-1:0]  simPix,
  input  logic [FRAMES*TAPS*WGT_W-1:0]  tapWgt,
  output logic [PIX_W-1:0]              pixOut,
  output logic [4*PIX_W-1:0]            wordOut
);
  localparam int RES_W  = PIX_W + 1;
  localparam int PROD_W = RES_W + WGT_W + 1;
  localparam int BR_W   = PROD_W + $clog2(TAPS);
  localparam int DEPTH  = $clog2(FRAMES + 1);
  localparam int LEAVES = 1 << DEPTH;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int ACC_W  = BR_W + DEPTH + 1;
  localparam int PMAX   = (1 << PIX_W) - 1;

  function automatic logic signed [PROD_W-1:0] tapProd(
      input logic [PIX_W-1:0] o, input logic [PIX_W-1:0] s, input logic [WGT_W-1:0] w);
    logic signed [RES_W-1:0] r;
    logic signed [WGT_W:0]   ws;
    r  = $signed({1'b0, o}) - $signed({1'b0, s});
    ws = $signed({1'b0, w});
    return PROD_W'(r) * PROD_W'(ws);
  endfunction

  // one residual branch per frame
  logic signed [BR_W-1:0] brSum [FRAMES];
  for (genvar f = 0; f < FRAMES; f++) begin : g_branch
    always_comb begin
      brSum[f] = '0;
      for (int t = 0; t < TAPS; t++) begin
        brSum[f] = brSum[f] + BR_W'(tapProd(obsPix[(f*TAPS+t)*PIX_W +: PIX_W],
                                             simPix[(f*TAPS+t)*PIX_W +: PIX_W],
                                             tapWgt[(f*TAPS+t)*WGT_W +: WGT_W]));
      end
    end
  end

  // leaves: branches, then the scaled current pixel, then zero padding
  logic signed [ACC_W-1:0] leafIn [LEAVES];
  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < FRAMES) begin : g_br
      assign leafIn[i] = ACC_W'(brSum[i]);
    end else if (i == FRAMES) begin : g_cur
      assign leafIn[i] = $signed(ACC_W'({curPix, FRAC_W'(0)}));
    end else begin : g_pad
      assign leafIn[i] = '0;
    end
  end

  // heap-ordered registered tree, node i has children 2i+1 and 2i+2
  logic signed [ACC_W-1:0] tree [NODES];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NODES; i++) tree[i] <= '0;
    end else begin
      for (int i = 0; i < LEAVES; i++) tree[LEAVES-1+i] <= leafIn[i];
      for (int i = 0; i < LEAVES - 1; i++) tree[i] <= tree[2*i+1] + tree[2*i+2];
    end
  end

  logic signed [ACC_W-1:0] rootSum, biased, shifted;
  logic [PIX_W-1:0]        rounded;
  always_comb begin
    rootSum = tree[0];
    biased  = rootSum + ACC_W'(1 << (FRAC_W - 1));
    shifted = biased >>> FRAC_W;
    if (shifted < 0)                         rounded = '0;
    else if (shifted > ACC_W'(PMAX))         rounded = PIX_W'(PMAX);
    else                                     rounded = shifted[PIX_W-1:0];
  end

  logic [PIX_W-1:0] packBuf [3];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut  <= '0;
      wordOut <= '0;
      for (int i = 0; i < 3; i++) packBuf[i] <= '0;
    end else if (stb.roundLoad) begin
      pixOut <= rounded;
      if (stb.slot != 2'd3) packBuf[stb.slot] <= rounded;
      if (stb.wordLoad) wordOut <= {rounded, packBuf[2], packBuf[1], packBuf[0]};
    end
  end

  assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.roundLoad && rootSum < 0) |=> (pixOut == '0));
  assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.roundLoad && rootSum >= ACC_W'(PMAX << FRAC_W)) |=> (pixOut == PIX_W'(PMAX)));
  assert_word_top_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.wordLoad |=> (wordOut[4*PIX_W-1 -: PIX_W] == pixOut));
endmodule

// File: rtl/bp_pixel_update.sv
module bp_pixel_update
  import bp_pkg::*;
#(
  parameter int FRAMES = 8,
  parameter int TAPS   = 4,
  parameter int WGT_W  = 8,
  parameter int FRAC_W = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [7:0]                  curPix,
  input  logic [FRAMES*TAPS*8-1:0]    obsPix,
  input  logic [FRAMES*TAPS*8-1:0]    simPix,
  input  logic [FRAMES*TAPS*WGT_W-1:0] tapWgt,
  output logic                        pixValid,
  output logic [7:0]                  pixOut,
  output logic                        wordValid,
  output logic [31:0]                 wordOut
);
  localparam int DEPTH = $clog2(FRAMES + 1);

  bpStrobe_t stb;

  bp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .stb(stb), .pixValid(pixValid), .wordValid(wordValid)
  );

  bp_datapath #(.FRAMES(FRAMES), .TAPS(TAPS), .PIX_W(8), .WGT_W(WGT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .curPix(curPix),
    .obsPix(obsPix), .simPix(simPix), .tapWgt(tapWgt),
    .pixOut(pixOut), .wordOut(wordOut)
  );
endmodule

// File: tb/sim_bp_pixel_update.sv
module sim_bp_pixel_update;
  localparam int K   = 8;
  localparam int T   = 4;
  localparam int W   = 8;
  localparam int F   = 6;
  localparam int LAT = $clog2(K + 1) + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] curPix = '0;
  logic [K*T*8-1:0] obsPix = '0, simPix = '0;
  logic [K*T*W-1:0] tapWgt = '0;
  logic pixValid, wordValid;
  logic [7:0] pixOut;
  logic [31:0] wordOut;

  bp_pixel_update #(.FRAMES(K), .TAPS(T), .WGT_W(W), .FRAC_W(F)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .curPix(curPix),
    .obsPix(obsPix), .simPix(simPix), .tapWgt(tapWgt),
    .pixValid(pixValid), .pixOut(pixOut), .wordValid(wordValid), .wordOut(wordOut)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int expQ [4096];
  int tagQ [4096];
  int stampQ [4096];
  int wp = 0, rp = 0, packCnt = 0;
  int grp [4];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input int req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int refPix();
    int s;
    s = int'(curPix) << F;
    for (int f = 0; f < K; f++)
      for (int t = 0; t < T; t++)
        s += (int'(obsPix[(f*T+t)*8 +: 8]) - int'(simPix[(f*T+t)*8 +: 8])) * int'(tapWgt[(f*T+t)*W +: W]);
    s = (s + (1 << (F - 1))) >>> F;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic clearIn();
    curPix = '0; obsPix = '0; simPix = '0; tapWgt = '0;
  endtask

  task automatic setTap(input int f, input int t, input int o, input int s, input int w);
    obsPix[(f*T+t)*8 +: 8] = 8'(o);
    simPix[(f*T+t)*8 +: 8] = 8'(s);
    tapWgt[(f*T+t)*W +: W] = W'(w);
  endtask

  task automatic randIn(input int zeroFrame);
    curPix = 8'($urandom);
    for (int f = 0; f < K; f++)
      for (int t = 0; t < T; t++)
        setTap(f, t, $urandom % 256, $urandom % 256, (f == zeroFrame) ? 0 : $urandom % 24);
  endtask

  // present the current inputs for one cycle; caller is at a negedge
  task automatic send(input int req);
    expQ[wp % 4096] = refPix();
    tagQ[wp % 4096] = req;
    stampQ[wp % 4096] = cyc;
    wp++;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      packCnt = 0;
    end else begin
      if (wordValid && !pixValid) check(0, 6, "word without pixel", 1, 0);
      if (pixValid) begin
        if (rp == wp) begin
          check(0, 9, "unexpected pixel", int'(pixOut), -1);
        end else begin
          check(int'(pixOut) == expQ[rp % 4096], tagQ[rp % 4096], "pixel value",
                int'(pixOut), expQ[rp % 4096]);
          check(cyc - stampQ[rp % 4096] == LAT, 2, "latency",
                cyc - stampQ[rp % 4096], LAT);  // R2
          grp[packCnt % 4] = expQ[rp % 4096];
          rp++;
          packCnt++;
          check(wordValid == (packCnt % 4 == 0), 6, "word strobe", int'(wordValid),
                int'(packCnt % 4 == 0));
          if (wordValid)
            check(wordOut == {8'(grp[3]), 8'(grp[2]), 8'(grp[1]), 8'(grp[0])}, 6, "packed word",
                  int'(wordOut), int'({8'(grp[3]), 8'(grp[2]), 8'(grp[1]), 8'(grp[0])}));
        end
      end
    end
  end

  task automatic drain();
    repeat (LAT + 3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8: reset state
    check(pixValid == 0 && wordValid == 0, 8, "valids in reset", int'(pixValid | wordValid), 0);
    check(pixOut == 0 && wordOut == 0, 8, "data in reset", int'(wordOut) | int'(pixOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: single unit-weight residual, and multi-frame sum
    clearIn(); curPix = 50; setTap(0, 0, 70, 60, 64); send(1);           // 60
    clearIn(); curPix = 20; setTap(1, 2, 100, 40, 32); setTap(5, 3, 10, 30, 128); send(1);
    // R4: exact halves round up, also for negative sums
    clearIn(); curPix = 100; setTap(2, 1, 11, 10, 32); send(4);         // 100.5 -> 101
    clearIn(); curPix = 100; setTap(3, 0, 10, 11, 32); send(4);         // 99.5 -> 100
    clearIn(); curPix = 100; setTap(4, 2, 10, 13, 32); send(4);         // 98.5 -> 99
    // R5: clamp high and low
    clearIn(); curPix = 200;
    for (int f = 0; f < K; f++) for (int t = 0; t < T; t++) setTap(f, t, 255, 0, 255);
    send(5);
    clearIn(); curPix = 30;
    for (int f = 0; f < K; f++) for (int t = 0; t < T; t++) setTap(f, t, 0, 255, 255);
    send(5);
    clearIn(); curPix = 255; setTap(0, 0, 1, 0, 64); send(5);           // 256 -> 255
    // R7: zero-weight frame with extreme pixels contributes nothing
    clearIn(); curPix = 77;
    for (int t = 0; t < T; t++) setTap(6, t, 255, 0, 0);
    send(7);
    randIn(3); send(7);
    randIn(0); send(7);
    drain();

    // R8: reset in the middle of a group, grouping restarts at the low byte
    randIn(-1); send(8);
    randIn(-1); send(8);
    drain();
    rstN = 1'b0;
    @(negedge clk);
    check(pixValid == 0 && wordValid == 0, 8, "valids after mid reset", int'(pixValid | wordValid), 0);
    check(wordOut == 0, 8, "word after mid reset", int'(wordOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin randIn(-1); send(8); end
    drain();

    // R3: back-to-back random run
    for (int i = 0; i < 200; i++) begin randIn(($urandom % 4 == 0) ? ($urandom % K) : -1); send(3); end
    drain();
    // R9: random idle gaps
    for (int i = 0; i < 300; i++) begin
      randIn(-1);
      send(9);
      repeat ($urandom % 3) @(negedge clk);
    end
    drain();
    check(rp == wp, 9, "all pixels returned", rp, wp);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 0, 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule